// File: doc/BRIEF.md
# Regulator enable and shutdown sequencer

This block decides when a multiphase regulator controller may leave shutdown and when it must go back. It combines a supply-good flag, a digitised enable-threshold comparator, a logic-level enable, a 6-bit voltage identification (VID) code and an overvoltage detect flag. From these it drives four outputs: a soft-start request, a tri-state control for the PWM outputs, a selector for the overvoltage trip level, and a latched overvoltage fault.

Two VID codes, 111111 and 111110, mean that no load is present. While the regulator runs, either code starts a wait of a parameterised number of switching-cycle ticks. When the wait ends, the PWM outputs are released to high impedance and the trip selector moves to the shutdown level. Any other code starts the regulator again. An overvoltage event latches a fault. Only a supply-good drop or an enable-comparator drop clears that fault; the no-load codes do not.

Top module: `vr_enable_seq`

## Requirements
- R1: `pwm_hiz` is 1 during reset and in every cycle in which the regulator is not running. It is 0 only while running, and that includes the no-load wait.
- R2: The regulator leaves shutdown only when all of these are true together: `por_ok`, `en_cmp` and `en_logic` are 1, `ov_fault` is 0, and the synchronised code is neither 111111 nor 111110.
- R3: `ss_start` is 1 in the very cycle in which the regulator is in shutdown and the conditions of R2 hold. On the next clock edge the regulator is running.
- R4: `vid` passes through two register stages before it is used. Both stages reset to 111111, so no start can happen until a real code has gone through them. A code applied before an edge is acted on from the second edge after it.
- R5: While running, a synchronised no-load code starts a wait. The regulator shuts down on the edge that ends with the second `sw_tick` counted during the wait. On that same edge `ov_lvl_sd` becomes 1, and it stays 1 until the next start clears it. The tick of the cycle in which the wait begins is not counted.
- R6: After a no-load shutdown, a code other than a no-load code (with the other enables still met) raises `ss_start` again.
- R7: `ov_detect` sets `ov_fault` on the next edge. A set fault forces shutdown on the edge after that, and no VID code clears it.
- R8: `ov_fault` is cleared on the next edge whenever `por_ok` or `en_cmp` is 0. Clearing takes priority over setting.
- R9: If `por_ok`, `en_cmp` or `en_logic` drops while running or waiting, the regulator is in shutdown after the next edge.
- R10: If the synchronised code leaves the no-load set during the wait, the wait is cancelled and the regulator keeps running. A later no-load code starts a fresh count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Bias supply above its power-on threshold |
| en_cmp | input | 1 | Enable threshold comparator output |
| en_logic | input | 1 | Logic-level enable |
| vid | input | 6 | Voltage identification code |
| ov_detect | input | 1 | Overvoltage detected |
| sw_tick | input | 1 | One-cycle pulse per switching period |
| ss_start | output | 1 | Soft-start request |
| pwm_hiz | output | 1 | Hold PWM outputs in high impedance |
| ov_lvl_sd | output | 1 | Overvoltage trip at the shutdown level |
| ov_fault | output | 1 | Latched overvoltage fault |

## Verification
The bench uses the default build: a 6-bit code, two synchroniser stages and a two-tick no-load wait. A two-tick wait is short enough that directed sequences can cover the wait, a cancel in mid-wait and the shutdown edge within a few cycles. The two-stage synchroniser lets every code change line up with a known edge. A biased random phase then mixes enable drops, faults and no-load codes into the wait and into the start cycle.

// File: rtl/vr_enable_seq.sv
module vr_enable_seq #(
  parameter int VID_W        = 6,
  parameter int SYNC_STAGES  = 2,
  parameter int NOLOAD_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_ok,
  input  logic             en_cmp,
  input  logic             en_logic,
  input  logic [VID_W-1:0] vid,
  input  logic             ov_detect,
  input  logic             sw_tick,
  output logic             ss_start,
  output logic             pwm_hiz,
  output logic             ov_lvl_sd,
  output logic             ov_fault
);
  localparam int CW = $clog2(NOLOAD_TICKS + 1);

  typedef enum logic [1:0] {ST_OFF, ST_RUN, ST_WAIT} st_t;

  st_t             st;
  logic [CW-1:0]   tick_cnt;
  logic [VID_W-1:0] sync_q [SYNC_STAGES];
  logic            go_ok, no_load, wait_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
    end else begin
      sync_q[0] <= vid;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign no_load   = &sync_q[SYNC_STAGES-1][VID_W-1:1];
  assign go_ok     = por_ok & en_cmp & en_logic & ~ov_fault;
  assign wait_done = sw_tick && (tick_cnt == CW'(NOLOAD_TICKS - 1));
  assign ss_start  = (st == ST_OFF) & go_ok & ~no_load;
  assign pwm_hiz   = (st == ST_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ov_fault <= 1'b0;
    else if (!por_ok || !en_cmp) ov_fault <= 1'b0;
    else if (ov_detect)          ov_fault <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OFF;
      tick_cnt  <= '0;
      ov_lvl_sd <= 1'b0;
    end else begin
      case (st)
        ST_OFF: if (ss_start) begin
          st        <= ST_RUN;
          ov_lvl_sd <= 1'b0;
        end
        ST_RUN: if (!go_ok) st <= ST_OFF;
          else if (no_load) begin
            st       <= ST_WAIT;
            tick_cnt <= '0;
          end
        ST_WAIT: if (!go_ok) st <= ST_OFF;
          else if (!no_load) st <= ST_RUN;
          else if (wait_done) begin
            st        <= ST_OFF;
            ov_lvl_sd <= 1'b1;
          end else if (sw_tick) tick_cnt <= tick_cnt + 1'b1;
        default: st <= ST_OFF;
      endcase
    end
  end
endmodule

module vr_enable_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic por_ok,
  input logic en_cmp,
  input logic en_logic,
  input logic ss_start,
  input logic pwm_hiz,
  input logic ov_lvl_sd,
  input logic ov_fault
);
  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start |-> (por_ok && en_cmp && en_logic && !ov_fault));
  p_start_runs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start |=> !pwm_hiz);
  p_lvl_with_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_lvl_sd) |-> $rose(pwm_hiz));
  p_fault_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ov_fault |=> pwm_hiz);
  p_fault_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_fault && por_ok && en_cmp) |=> ov_fault);
  p_fault_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_ok || !en_cmp) |=> !ov_fault);
  p_drop_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_ok || !en_cmp || !en_logic) |=> pwm_hiz);
  p_hiz_no_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_hiz |-> !ss_start);
endmodule

bind vr_enable_seq vr_enable_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_cmp(en_cmp),
  .en_logic(en_logic), .ss_start(ss_start), .pwm_hiz(pwm_hiz),
  .ov_lvl_sd(ov_lvl_sd), .ov_fault(ov_fault)
);

// File: tb/vr_enable_seq_test.sv
module vr_enable_seq_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic por_ok = 1, en_cmp = 1, en_logic = 1, ov_detect = 0, sw_tick = 0;
  logic [5:0] vid = 6'h3F;
  logic ss_start, pwm_hiz, ov_lvl_sd, ov_fault;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  vr_enable_seq uut (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_cmp(en_cmp),
    .en_logic(en_logic), .vid(vid), .ov_detect(ov_detect), .sw_tick(sw_tick),
    .ss_start(ss_start), .pwm_hiz(pwm_hiz), .ov_lvl_sd(ov_lvl_sd), .ov_fault(ov_fault)
  );

  // reference model: 0 off, 1 running, 2 waiting on a no-load code
  int m_mode = 0, m_ticks = 0;
  bit m_lvl = 0, m_fault = 0;
  int vq[$] = '{63, 63};

  function automatic bit is_noload(int c);
    return (c == 63) || (c == 62);
  endfunction

  function automatic bit m_go();
    return por_ok && en_cmp && en_logic && !m_fault;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ticks = 0; m_lvl = 0; m_fault = 0; vq = '{63, 63};
    end else begin
      bit go, nl, nf;
      go = m_go();
      nl = is_noload(vq[0]);
      nf = (!por_ok || !en_cmp) ? 1'b0 : (m_fault || ov_detect);
      if (m_mode == 0) begin
        if (go && !nl) begin m_mode = 1; m_lvl = 0; end
      end else if (!go) m_mode = 0;
      else if (m_mode == 1) begin
        if (nl) begin m_mode = 2; m_ticks = 0; end
      end else if (!nl) m_mode = 1;
      else if (sw_tick) begin
        m_ticks++;
        if (m_ticks == 2) begin m_mode = 0; m_lvl = 1; end
      end
      m_fault = nf;
      vq.push_back(int'(vid));
      void'(vq.pop_front());
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R1 pwm_hiz", pwm_hiz, m_mode == 0);
    chk("R3 ss_start", ss_start, (m_mode == 0) && m_go() && !is_noload(vq[0]));
    chk("R5 ov_lvl_sd", ov_lvl_sd, m_lvl);
    chk("R7 ov_fault", ov_fault, m_fault);
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #(PERIOD/4);
      cmp_all();
      sw_tick = 0;
      ov_detect = 0;
    end
  endtask

  task automatic tick_step();
    sw_tick = 1;
    step(1);
  endtask

  initial begin
    #(PERIOD*200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    step(3);
    chk("R1 reset hiz", pwm_hiz, 1'b1);
    rst_n = 1;
    step(3);
    chk("R4 reset code blocks start", pwm_hiz, 1'b1);
    vid = 6'h20;
    step(2);
    chk("R4 still off after two edges", pwm_hiz, 1'b1);
    chk("R3 start request", ss_start, 1'b1);
    step(1);
    chk("R2 running", pwm_hiz, 1'b0);
    por_ok = 0;
    step(1);
    chk("R9 supply drop", pwm_hiz, 1'b1);
    por_ok = 1; step(2);
    en_logic = 0; step(2);
    chk("R2 logic enable low keeps off", pwm_hiz, 1'b1);
    en_logic = 1; step(2);
    // no-load wait and shutdown
    vid = 6'h3E; step(3);
    chk("R5 waiting still drives", pwm_hiz, 1'b0);
    tick_step(); step(1);
    chk("R5 one tick not enough", pwm_hiz, 1'b0);
    tick_step();
    chk("R5 off on second tick", pwm_hiz, 1'b1);
    chk("R5 trip level", ov_lvl_sd, 1'b1);
    vid = 6'h15; step(2);
    chk("R6 restart request", ss_start, 1'b1);
    step(1);
    chk("R6 running again", pwm_hiz, 1'b0);
    // cancel during wait
    vid = 6'h3F; step(3); tick_step();
    vid = 6'h10; step(3);
    vid = 6'h3F; step(3); tick_step(); step(1);
    chk("R10 count restarted", pwm_hiz, 1'b0);
    tick_step();
    chk("R10 fresh count ends wait", pwm_hiz, 1'b1);
    vid = 6'h08; step(4);
    // overvoltage latch
    ov_detect = 1; step(1);
    chk("R7 fault set", ov_fault, 1'b1);
    step(1);
    chk("R7 fault stops", pwm_hiz, 1'b1);
    vid = 6'h3F; step(4); vid = 6'h3E; step(4); vid = 6'h11; step(4);
    chk("R7 codes do not clear", ov_fault, 1'b1);
    en_cmp = 0; ov_detect = 1; step(1);
    chk("R8 clear wins", ov_fault, 1'b0);
    en_cmp = 1; step(4);
    chk("R8 restarts after clear", pwm_hiz, 1'b0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      por_ok    = ($urandom_range(0, 40) != 0);
      en_cmp    = ($urandom_range(0, 40) != 0);
      en_logic  = ($urandom_range(0, 30) != 0);
      ov_detect = ($urandom_range(0, 60) == 0);
      sw_tick   = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 6) == 0)
        vid = ($urandom_range(0, 1) != 0) ? 6'(62 + $urandom_range(0, 1)) : 6'($urandom_range(0, 61));
      @(posedge clk);
      #(PERIOD/4);
      cmp_all();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule